// File: doc/BRIEF.md
# D-PHY Power-Up Sequencer

This block brings a serial display PHY out of power-down once its parameters have been programmed. A single start pulse makes it release three control bits in a fixed staged order: first the clock enable, then the shutdown release, then the reset release. Each early stage is held for a set number of system clocks. After the last release it waits a long settle time and then samples the PHY status at spaced instants until the PLL reports lock or the clock lane reports stop state. If neither shows up within a bounded number of tries, a timeout flag is raised instead of the ready flag.

A disable request drops all three control bits together on the next clock, from any state. All delays are counted in system clocks and set by parameters, so the defaults can match real microsecond and millisecond figures while a bench uses short values. The analog PHY and its timing-parameter programming sit outside this block.

States: IDLE (all bits low), CLK_ON (clock enable only), PWR_ON (clock enable plus shutdown release), SETTLE (all three bits, waiting), POLL (one status sample), GAP (wait between samples), READY (lock seen) and FAIL (tries used up). Transitions: IDLE to CLK_ON on start; CLK_ON to PWR_ON and PWR_ON to SETTLE when the stage timer runs out; SETTLE to POLL when the settle timer runs out; POLL to READY on good status, POLL to FAIL on the last failed try, POLL to GAP otherwise; GAP back to POLL when the gap timer runs out; any state to IDLE on disable.

Top module: `dphy_pwrup_seq`

## Requirements
- R1: After reset `phy_ctl` is 000 and both flags are low; in IDLE a start request makes `phy_ctl` read 100 in the cycle after it is sampled.
- R2: `phy_ctl` bit 2 is the clock enable, bit 0 the shutdown release, bit 1 the reset release; the value steps only 000, 100, 101, 111 in that order.
- R3: The value 100 is held for exactly STAGE_CYC cycles and 101 for exactly STAGE_CYC cycles.
- R4: After 111 appears it is held SETTLE_CYC cycles before the first status sample; further samples follow every POLL_GAP_CYC+1 cycles, and status between sample instants is ignored.
- R5: A sample is good when status bit 0 (lock) or bit 2 (clock-lane stop) is set; bit 1 alone is not. On a good sample `ready` rises in the next cycle and stays high with `phy_ctl` at 111 until disable.
- R6: After MAX_TRIES bad samples `timed_out` rises in the next cycle, `phy_ctl` stays 111, and the flag holds until disable; `ready` and `timed_out` are never both high.
- R7: A disable request in any state gives `phy_ctl` 000 and both flags low in the next cycle, and wins over a simultaneous start.
- R8: A start request outside IDLE (mid-sequence, ready or timed out) has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_req | input | 1 | Begin the power-up sequence (accepted in IDLE only) |
| stop_req | input | 1 | Disable: clear all control bits |
| phy_status | input | 3 | PHY status; bit 0 PLL lock, bit 2 clock-lane stop state |
| phy_ctl | output | 3 | Control bits; bit 2 clock enable, bit 1 reset release, bit 0 shutdown release |
| ready | output | 1 | PHY reported ready |
| timed_out | output | 1 | Poll budget used up without a good sample |

## Verification
The bench targets exact stage and settle lengths, where an off-by-one timer would shift the 101 or 111 step by a cycle, and the sample instants, by holding good status during settle and gap cycles so that a design sampling continuously would raise `ready` early. It drives status bit 1 alone on every failing try so that a decoder taking any set bit would never time out, and runs the full try budget so a miscounted try counter fires early or late. Start is held high through whole sequences and in the ready and timeout states to catch a restart, and a disable arrives together with start and mid-stage to check its priority and immediacy.

// File: rtl/dphy_seq_pkg.sv
package dphy_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLK_ON,
        ST_PWR_ON,
        ST_SETTLE,
        ST_POLL,
        ST_GAP,
        ST_READY,
        ST_FAIL
    } seq_state_t;

    localparam int CTL_W  = 3;
    localparam int STAT_W = 3;

    // control bit encodings as seen by the PHY
    localparam logic [CTL_W-1:0] CTL_OFF  = 3'b000;
    localparam logic [CTL_W-1:0] CTL_CLK  = 3'b100;
    localparam logic [CTL_W-1:0] CTL_PWR  = 3'b101;
    localparam logic [CTL_W-1:0] CTL_FULL = 3'b111;

    // status bits that count as "ready": lock (0) and clock-lane stop (2)
    localparam logic [STAT_W-1:0] STAT_OK_MASK = 3'b101;

endpackage

// File: rtl/dphy_seq_timer.sv
module dphy_seq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/dphy_seq_tries.sv
module dphy_seq_tries #(
    parameter int MAX_TRIES = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic bump,
    output logic last
);

    localparam int CW = $clog2(MAX_TRIES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clear)
            cnt <= '0;
        else if (bump)
            cnt <= cnt + 1'b1;
    end

    assign last = (cnt == CW'(MAX_TRIES - 1));

endmodule

// File: rtl/dphy_pwrup_seq.sv
module dphy_pwrup_seq
    import dphy_seq_pkg::*;
#(
    parameter int STAGE_CYC    = 100,
    parameter int SETTLE_CYC   = 100000,
    parameter int POLL_GAP_CYC = 100,
    parameter int MAX_TRIES    = 100
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_req,
    input  logic        stop_req,
    input  logic [2:0]  phy_status,
    output logic [2:0]  phy_ctl,
    output logic        ready,
    output logic        timed_out
);

    localparam int LONG_A = (STAGE_CYC > POLL_GAP_CYC) ? STAGE_CYC : POLL_GAP_CYC;
    localparam int LONGEST = (SETTLE_CYC > LONG_A) ? SETTLE_CYC : LONG_A;
    localparam int TMR_W = $clog2(LONGEST + 1);

    localparam logic [TMR_W-1:0] STAGE_LD  = TMR_W'(STAGE_CYC - 1);
    localparam logic [TMR_W-1:0] SETTLE_LD = TMR_W'(SETTLE_CYC - 1);
    localparam logic [TMR_W-1:0] GAP_LD    = TMR_W'(POLL_GAP_CYC - 1);

    seq_state_t       state, nxt;
    logic             tmr_load, tmr_done;
    logic [TMR_W-1:0] tmr_val;
    logic             try_clr, try_bump, try_last;
    logic             stat_ok;

    assign stat_ok = |(phy_status & STAT_OK_MASK);

    dphy_seq_timer #(.W(TMR_W)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    dphy_seq_tries #(.MAX_TRIES(MAX_TRIES)) i_tries (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (try_clr),
        .bump  (try_bump),
        .last  (try_last)
    );

    // next state and timer/counter control
    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        try_clr  = 1'b0;
        try_bump = 1'b0;
        if (stop_req) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: if (start_req) begin
                    nxt      = ST_CLK_ON;
                    tmr_load = 1'b1;
                    tmr_val  = STAGE_LD;
                end
                ST_CLK_ON: if (tmr_done) begin
                    nxt      = ST_PWR_ON;
                    tmr_load = 1'b1;
                    tmr_val  = STAGE_LD;
                end
                ST_PWR_ON: if (tmr_done) begin
                    nxt      = ST_SETTLE;
                    tmr_load = 1'b1;
                    tmr_val  = SETTLE_LD;
                end
                ST_SETTLE: if (tmr_done) begin
                    nxt     = ST_POLL;
                    try_clr = 1'b1;
                end
                ST_POLL: begin
                    if (stat_ok) begin
                        nxt = ST_READY;
                    end else if (try_last) begin
                        nxt = ST_FAIL;
                    end else begin
                        nxt      = ST_GAP;
                        tmr_load = 1'b1;
                        tmr_val  = GAP_LD;
                        try_bump = 1'b1;
                    end
                end
                ST_GAP: if (tmr_done) nxt = ST_POLL;
                ST_READY: nxt = ST_READY;
                ST_FAIL:  nxt = ST_FAIL;
                default:  nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    // outputs decoded from state
    always_comb begin
        phy_ctl   = CTL_OFF;
        ready     = 1'b0;
        timed_out = 1'b0;
        unique case (state)
            ST_IDLE:   phy_ctl = CTL_OFF;
            ST_CLK_ON: phy_ctl = CTL_CLK;
            ST_PWR_ON: phy_ctl = CTL_PWR;
            ST_SETTLE, ST_POLL, ST_GAP: phy_ctl = CTL_FULL;
            ST_READY: begin
                phy_ctl = CTL_FULL;
                ready   = 1'b1;
            end
            ST_FAIL: begin
                phy_ctl   = CTL_FULL;
                timed_out = 1'b1;
            end
            default: phy_ctl = CTL_OFF;
        endcase
    end

endmodule

// File: rtl/dphy_pwrup_seq_chk.sv
module dphy_pwrup_seq_chk #(
    parameter int STAGE_CYC = 100
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start_req,
    input logic       stop_req,
    input logic [2:0] phy_ctl,
    input logic       ready,
    input logic       timed_out
);

    localparam int CW = $clog2(STAGE_CYC + 1) + 1;

    logic [CW-1:0] clk_only_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            clk_only_cnt <= '0;
        else if (phy_ctl == 3'b100)
            clk_only_cnt <= clk_only_cnt + 1'b1;
        else
            clk_only_cnt <= '0;
    end

    AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop_req && start_req && phy_ctl == 3'b000) |=> (phy_ctl == 3'b100)); // R1

    AST_CTL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_ctl == 3'b000 || phy_ctl == 3'b100 || phy_ctl == 3'b101 || phy_ctl == 3'b111)); // R2

    AST_SHD_AFTER_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phy_ctl[0]) |-> ($past(phy_ctl) == 3'b100)); // R2

    AST_RST_AFTER_SHD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phy_ctl[1]) |-> ($past(phy_ctl) == 3'b101)); // R2

    AST_CLK_STAGE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_ctl == 3'b100 && !stop_req && clk_only_cnt == CW'(STAGE_CYC - 1)) |=> (phy_ctl == 3'b101)); // R3

    AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !stop_req) |=> (ready && phy_ctl == 3'b111)); // R5

    AST_TIMEOUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (timed_out && !stop_req) |=> (timed_out && phy_ctl == 3'b111)); // R6

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(ready && timed_out)); // R6

    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |=> (phy_ctl == 3'b000 && !ready && !timed_out)); // R7

    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop_req && phy_ctl == 3'b111) |=> (phy_ctl == 3'b111)); // R8

endmodule

bind dphy_pwrup_seq dphy_pwrup_seq_chk #(.STAGE_CYC(STAGE_CYC)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (start_req),
    .stop_req  (stop_req),
    .phy_ctl   (phy_ctl),
    .ready     (ready),
    .timed_out (timed_out)
);

// File: tb/test_dphy_pwrup_seq.sv
`timescale 1ns/1ps
module test_dphy_pwrup_seq;

    localparam int P_STAGE  = 4;
    localparam int P_SETTLE = 12;
    localparam int P_GAP    = 3;
    localparam int P_TRIES  = 100;
    localparam int WATCHDOG = 50000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_req = 1'b0;
    logic       stop_req = 1'b0;
    logic [2:0] phy_status = 3'b000;
    logic [2:0] phy_ctl;
    logic       ready;
    logic       timed_out;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    logic [4:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    dphy_pwrup_seq #(
        .STAGE_CYC    (P_STAGE),
        .SETTLE_CYC   (P_SETTLE),
        .POLL_GAP_CYC (P_GAP),
        .MAX_TRIES    (P_TRIES)
    ) i_dphy_pwrup_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_req  (start_req),
        .stop_req   (stop_req),
        .phy_status (phy_status),
        .phy_ctl    (phy_ctl),
        .ready      (ready),
        .timed_out  (timed_out)
    );

    // driver: set inputs for the next edge and queue the outputs expected after it
    task automatic step(input logic st, input logic sp, input logic [2:0] ps,
                        input logic [2:0] ec, input logic er, input logic et,
                        input string tag);
        @(negedge clk);
        start_req  = st;
        stop_req   = sp;
        phy_status = ps;
        exp_q.push_back({ec, er, et});
        tag_q.push_back(tag);
    endtask

    // monitor: compare after each edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                logic [4:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if ({phy_ctl, ready, timed_out} !== e) begin
                    fails++;
                    $display("FAIL %s: got ctl=%b rdy=%b tmo=%b, expected ctl=%b rdy=%b tmo=%b",
                             t, phy_ctl, ready, timed_out, e[4:2], e[1], e[0]);
                end
            end
        end
    end

    // full sequence; ok_try < 0 means no try succeeds
    task automatic launch(input int ok_try, input logic [2:0] good,
                          input bit noise, input bit hs);
        logic [2:0] idle_st;
        idle_st = noise ? good : 3'b000;
        step(1'b1, 1'b0, idle_st, 3'b100, 1'b0, 1'b0, "R1");
        for (int i = 1; i < P_STAGE; i++) step(hs, 1'b0, idle_st, 3'b100, 1'b0, 1'b0, "R3");
        for (int i = 0; i < P_STAGE; i++) step(hs, 1'b0, idle_st, 3'b101, 1'b0, 1'b0, "R2");
        for (int i = 0; i < P_SETTLE; i++) step(hs, 1'b0, idle_st, 3'b111, 1'b0, 1'b0, "R4");
        for (int k = 0; k < P_TRIES; k++) begin
            step(hs, 1'b0, idle_st, 3'b111, 1'b0, 1'b0, "R4");
            if (k == ok_try) begin
                step(hs, 1'b0, good, 3'b111, 1'b1, 1'b0, "R5");
                return;
            end
            if (k == P_TRIES - 1) begin
                step(hs, 1'b0, 3'b010, 3'b111, 1'b0, 1'b1, "R6");
                return;
            end
            step(hs, 1'b0, 3'b010, 3'b111, 1'b0, 1'b0, "R5");
            for (int g = 1; g < P_GAP; g++) step(hs, 1'b0, idle_st, 3'b111, 1'b0, 1'b0, "R4");
        end
    endtask

    task automatic hold(input int n, input logic st, input logic er, input logic et,
                        input string tag);
        for (int i = 0; i < n; i++) step(st, 1'b0, 3'b000, 3'b111, er, et, tag);
    endtask

    task automatic shut(input logic st);
        step(st, 1'b1, 3'b000, 3'b000, 1'b0, 1'b0, "R7");
        step(1'b0, 1'b0, 3'b000, 3'b000, 1'b0, 1'b0, "R7");
    endtask

    task automatic finish_up;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < WATCHDOG; i++) begin
            @(posedge clk);
            if (finished) break;
        end
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: got no end after %0d cycles, expected completion", WATCHDOG);
            finish_up();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, idle stays idle
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 3'b000, 3'b000, 1'b0, 1'b0, "R1");

        // lock on first try, start ignored while ready (R8)
        launch(0, 3'b001, 1'b0, 1'b0);
        hold(3, 1'b1, 1'b1, 1'b0, "R8");
        shut(1'b0);

        // stop-state bit on fourth try, good status present between samples
        launch(3, 3'b100, 1'b1, 1'b0);
        hold(2, 1'b0, 1'b1, 1'b0, "R5");
        shut(1'b0);

        // only bit 1 ever set: full timeout, start ignored afterwards, stop beats start
        launch(-1, 3'b000, 1'b0, 1'b0);
        hold(3, 1'b1, 1'b0, 1'b1, "R8");
        shut(1'b1);

        // start held high through the whole run
        launch(2, 3'b101, 1'b1, 1'b1);
        hold(2, 1'b1, 1'b1, 1'b0, "R8");
        shut(1'b1);

        // disable in the middle of the clock-only stage
        step(1'b1, 1'b0, 3'b000, 3'b100, 1'b0, 1'b0, "R1");
        step(1'b0, 1'b0, 3'b000, 3'b100, 1'b0, 1'b0, "R3");
        shut(1'b0);

        // disable during settle
        step(1'b1, 1'b0, 3'b000, 3'b100, 1'b0, 1'b0, "R1");
        for (int i = 1; i < P_STAGE; i++) step(1'b0, 1'b0, 3'b000, 3'b100, 1'b0, 1'b0, "R3");
        for (int i = 0; i < P_STAGE; i++) step(1'b0, 1'b0, 3'b000, 3'b101, 1'b0, 1'b0, "R2");
        step(1'b0, 1'b0, 3'b000, 3'b111, 1'b0, 1'b0, "R4");
        shut(1'b0);

        @(posedge clk);
        #4;
        finished = 1'b1;
        finish_up();
    end

endmodule